// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block is the distribution stage of a multi-core interrupt controller. It takes one level-sensitive request line per interrupt source, applies a global enable to the shared sources, and applies a per-source routing word that picks the cores each source may interrupt. The routing word has one IRQ-delivery bit and one FIQ-delivery bit per core. The block delivers two pending vectors, one for IRQ and one for FIQ, each holding one bit per core and source. A per-core interface downstream takes these vectors.

Software reaches the block through a zero-wait-state APB-style register port. To turn on a source, software writes that source's index to a set-enable address. To turn it off, software writes the index to a clear-enable address. The routing word of each source has its own word in a routing window. A read-only control word reports how many sources the block implements.

The pending outputs are plain levels and have no handshake. The register port never stalls, so it applies no back-pressure. Every access completes in its access phase.

Top module: `irq_distributor`

## Requirements
- R1: A read at offset 0x00 returns the number of implemented sources (NUM_SRC) in bits [11:2]. All other bits read as zero.
- R2: Writing a value n below NUM_SRC to offset 0x30 sets the global enable of source n. Writing n to offset 0x34 clears it.
- R3: The routing word of source n is at offset 0x100 + 4*n. Bit c (c < NUM_CPU) routes the source's IRQ to core c, and bit 8+c routes its FIQ to core c. The word reads back as written, and bits that are not implemented read as zero.
- R4: A shared source (index 29 and above) raises IRQ pending for core c only when all three hold: its input is high, its global enable is set, and its IRQ bit for c is set. FIQ pending follows the same rule using the FIQ bit. Pending bit c*NUM_SRC+n belongs to core c and source n.
- R5: A private source (index 28 and below) raises pending from its input and its routing bit alone. Its global enable has no effect.
- R6: After reset all enables and routing words are zero, so no pending bit is set, even with every input high.
- R7: A write to 0x30 or 0x34 whose data is NUM_SRC or above changes no enable. In particular, it must not act on the data truncated to the index width.
- R8: A write to the routing window at or beyond index NUM_SRC changes no routing word. Reads there, and at 0x30, 0x34 or any unmapped offset, return zero.
- R9: A register write takes effect on the clock edge that ends its access phase, and pending does not change before that edge. Pending follows the source inputs with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register and state clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset of the access |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high with pwrite low |
| src_i | input | NUM_SRC | Level request of each source |
| irq_pend_o | output | NUM_CPU*NUM_SRC | IRQ pending, bit c*NUM_SRC+n for core c, source n |
| fiq_pend_o | output | NUM_CPU*NUM_SRC | FIQ pending, same indexing |

## Verification
The bench builds the block with NUM_SRC = 36 and NUM_CPU = 2. With these values the seven shared sources 29 to 35 sit beside the private ones, the first index out of range (36) is a valid routing address, and 94 is an index that aliases to a shared source when truncated to six bits. Random enable, clear, routing and input traffic then reaches both sides of the private/shared boundary and the last valid source. Directed cases cover the edge timing of a write and the out-of-range writes.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int OFF_CTL        = 'h000;
  localparam int OFF_EN_SET     = 'h030;
  localparam int OFF_EN_CLR     = 'h034;
  localparam int OFF_ROUTE_BASE = 'h100;
  localparam int CNT_LSB        = 2;
  localparam int FIQ_LSB        = 8;
  localparam int PRIV_LAST      = 28;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic route_wr;
    logic ctl_rd;
    logic route_rd;
  } irqd_acc_t;
endpackage

// File: rtl/irqd_apb_decode.sv
module irqd_apb_decode
  import irqd_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output irqd_acc_t         acc_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  route_idx_o
);
  localparam int ROUTE_END = OFF_ROUTE_BASE + 4 * NUM_SRC;

  logic [31:0] addr32;
  logic        wr_acc;
  logic        rd_acc;
  logic        idx_ok;
  logic        in_route;

  assign addr32   = 32'(paddr);
  assign wr_acc   = psel & penable & pwrite;
  assign rd_acc   = psel & ~pwrite;
  assign idx_ok   = pwdata < 32'(NUM_SRC);
  assign in_route = (addr32 >= 32'(OFF_ROUTE_BASE)) && (addr32 < 32'(ROUTE_END))
                    && (paddr[1:0] == 2'b00);

  always_comb begin
    acc_o          = '0;
    acc_o.set_en   = wr_acc && idx_ok && (addr32 == 32'(OFF_EN_SET));
    acc_o.clr_en   = wr_acc && idx_ok && (addr32 == 32'(OFF_EN_CLR));
    acc_o.route_wr = wr_acc && in_route;
    acc_o.ctl_rd   = rd_acc && (addr32 == 32'(OFF_CTL));
    acc_o.route_rd = rd_acc && in_route;
  end

  assign wr_idx_o    = pwdata[IDX_W-1:0];
  assign route_idx_o = IDX_W'((addr32 - 32'(OFF_ROUTE_BASE)) >> 2);
endmodule

// File: rtl/irqd_enable_bank.sv
module irqd_enable_bank
  import irqd_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_SRC-1:0] gate_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    if (n <= PRIV_LAST) begin : g_priv
      assign gate_o[n] = 1'b1;
    end else begin : g_shared
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          en_q <= 1'b0;
        else if (set_i && idx_i == IDX_W'(n))
          en_q <= 1'b1;
        else if (clr_i && idx_i == IDX_W'(n))
          en_q <= 1'b0;
      end
      assign gate_o[n] = en_q;

      assert_set_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && idx_i == IDX_W'(n)) |=> en_q);
      assert_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && idx_i == IDX_W'(n)) |=> !en_q);
    end
  end
endmodule

// File: rtl/irqd_route_bank.sv
module irqd_route_bank #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int IDX_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NUM_CPU-1:0]         irq_d_i,
  input  logic [NUM_CPU-1:0]         fiq_d_i,
  output logic [NUM_SRC*NUM_CPU-1:0] irq_route_o,
  output logic [NUM_SRC*NUM_CPU-1:0] fiq_route_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_word
    logic [NUM_CPU-1:0] irq_q;
    logic [NUM_CPU-1:0] fiq_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q <= '0;
        fiq_q <= '0;
      end else if (wr_i && idx_i == IDX_W'(n)) begin
        irq_q <= irq_d_i;
        fiq_q <= fiq_d_i;
      end
    end
    assign irq_route_o[n*NUM_CPU +: NUM_CPU] = irq_q;
    assign fiq_route_o[n*NUM_CPU +: NUM_CPU] = fiq_q;

    assert_route_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && idx_i == IDX_W'(n)) |=> (irq_q == $past(irq_d_i) && fiq_q == $past(fiq_d_i)));
  end
endmodule

// File: rtl/irqd_pend_gen.sv
module irqd_pend_gen #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic [NUM_SRC-1:0]         src_i,
  input  logic [NUM_SRC-1:0]         gate_i,
  input  logic [NUM_SRC*NUM_CPU-1:0] irq_route_i,
  input  logic [NUM_SRC*NUM_CPU-1:0] fiq_route_i,
  output logic [NUM_CPU*NUM_SRC-1:0] irq_pend_o,
  output logic [NUM_CPU*NUM_SRC-1:0] fiq_pend_o
);
  logic [NUM_SRC-1:0] live;
  assign live = src_i & gate_i;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign irq_pend_o[c*NUM_SRC+n] = live[n] & irq_route_i[n*NUM_CPU+c];
      assign fiq_pend_o[c*NUM_SRC+n] = live[n] & fiq_route_i[n*NUM_CPU+c];
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                       pclk,
  input  logic                       presetn,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [31:0]                pwdata,
  output logic [31:0]                prdata,
  input  logic [NUM_SRC-1:0]         src_i,
  output logic [NUM_CPU*NUM_SRC-1:0] irq_pend_o,
  output logic [NUM_CPU*NUM_SRC-1:0] fiq_pend_o
);
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int ROUTE_END = OFF_ROUTE_BASE + 4 * NUM_SRC;

  irqd_acc_t                  acc;
  logic [IDX_W-1:0]           wr_idx;
  logic [IDX_W-1:0]           route_idx;
  logic [NUM_SRC-1:0]         gate;
  logic [NUM_SRC*NUM_CPU-1:0] irq_route;
  logic [NUM_SRC*NUM_CPU-1:0] fiq_route;

  irqd_apb_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_decode (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .acc_o(acc), .wr_idx_o(wr_idx), .route_idx_o(route_idx)
  );

  irqd_enable_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enable (
    .clk(pclk), .rst_n(presetn), .set_i(acc.set_en), .clr_i(acc.clr_en),
    .idx_i(wr_idx), .gate_o(gate)
  );

  irqd_route_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_route (
    .clk(pclk), .rst_n(presetn), .wr_i(acc.route_wr), .idx_i(route_idx),
    .irq_d_i(pwdata[NUM_CPU-1:0]), .fiq_d_i(pwdata[FIQ_LSB +: NUM_CPU]),
    .irq_route_o(irq_route), .fiq_route_o(fiq_route)
  );

  irqd_pend_gen #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_pend (
    .src_i(src_i), .gate_i(gate), .irq_route_i(irq_route), .fiq_route_i(fiq_route),
    .irq_pend_o(irq_pend_o), .fiq_pend_o(fiq_pend_o)
  );

  always_comb begin
    prdata = '0;
    if (acc.ctl_rd) begin
      prdata[CNT_LSB +: 10] = 10'(NUM_SRC);
    end else if (acc.route_rd) begin
      prdata[NUM_CPU-1:0]       = irq_route[route_idx*NUM_CPU +: NUM_CPU];
      prdata[FIQ_LSB +: NUM_CPU] = fiq_route[route_idx*NUM_CPU +: NUM_CPU];
    end
  end

  // Raw (undecoded) out-of-range writes, used only by the checks below
  logic en_wr_oob;
  logic route_wr_oob;
  assign en_wr_oob    = psel && penable && pwrite && (pwdata >= 32'(NUM_SRC)) &&
                        (32'(paddr) == 32'(OFF_EN_SET) || 32'(paddr) == 32'(OFF_EN_CLR));
  assign route_wr_oob = psel && penable && pwrite && (32'(paddr) >= 32'(ROUTE_END));

  assert_ctl_count_R1: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && 32'(paddr) == 32'(OFF_CTL)) |-> (prdata[CNT_LSB +: 10] == 10'(NUM_SRC)));
  assert_en_oob_R7: assert property (@(posedge pclk) disable iff (!presetn)
    en_wr_oob |=> $stable(gate));
  assert_route_oob_R8: assert property (@(posedge pclk) disable iff (!presetn)
    route_wr_oob |=> ($stable(irq_route) && $stable(fiq_route)));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_chk_src
      assert_quiet_src_R9: assert property (@(posedge pclk) disable iff (!presetn)
        !src_i[n] |-> (!irq_pend_o[c*NUM_SRC+n] && !fiq_pend_o[c*NUM_SRC+n]));
      if (n > PRIV_LAST) begin : g_sh
        assert_shared_gate_R4: assert property (@(posedge pclk) disable iff (!presetn)
          (irq_pend_o[c*NUM_SRC+n] || fiq_pend_o[c*NUM_SRC+n]) |-> gate[n]);
      end else begin : g_pr
        assert_private_R5: assert property (@(posedge pclk) disable iff (!presetn)
          (src_i[n] && irq_route[n*NUM_CPU+c]) |-> irq_pend_o[c*NUM_SRC+n]);
      end
    end
  end
endmodule

// File: tb/irq_distributor_bench.sv
`timescale 1ns/1ps
module irq_distributor_bench;
  localparam int NS = 36;
  localparam int NC = 2;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0]     paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic [NS-1:0]     src = '0;
  logic [NC*NS-1:0]  irq_pend, fiq_pend;

  irq_distributor #(.ADDR_W(AW), .NUM_SRC(NS), .NUM_CPU(NC)) u_irq_distributor (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .src_i(src),
    .irq_pend_o(irq_pend), .fiq_pend_o(fiq_pend)
  );

  logic          m_en  [NS];
  logic [NC-1:0] m_irq [NS];
  logic [NC-1:0] m_fiq [NS];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [NC*NS-1:0] exp_pend(bit fiq);
    logic [NC*NS-1:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < NS; n++) begin
        logic g = (n <= 28) ? 1'b1 : m_en[n];
        logic r = fiq ? m_fiq[n][c] : m_irq[n][c];
        v[c*NS+n] = src[n] & g & r;
      end
    return v;
  endfunction

  function automatic logic [31:0] exp_word(int idx);
    logic [31:0] w = '0;
    if (idx < NS) begin
      w[NC-1:0] = m_irq[idx];
      w[8 +: NC] = m_fiq[idx];
    end
    return w;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_pend(string req);
    #1;
    check(irq_pend == exp_pend(0), req, "irq pending", 128'(irq_pend), 128'(exp_pend(0)));
    check(fiq_pend == exp_pend(1), req, "fiq pending", 128'(fiq_pend), 128'(exp_pend(1)));
  endtask

  task automatic apb_write(int addr, logic [31:0] data);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = AW'(addr); pwdata = data;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(int addr, output logic [31:0] data);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = AW'(addr);
    @(negedge clk);
    penable = 1;
    #1 data = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic en_write(bit set, logic [31:0] idx);
    apb_write(set ? 'h30 : 'h34, idx);
    if (idx < NS) m_en[idx] = set;
  endtask

  task automatic route_write(int idx, logic [31:0] d);
    apb_write('h100 + 4*idx, d);
    if (idx < NS) begin
      m_irq[idx] = d[NC-1:0];
      m_fiq[idx] = d[8 +: NC];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h1ac3_5eed));
    for (int n = 0; n < NS; n++) begin
      m_en[n] = 0; m_irq[n] = '0; m_fiq[n] = '0;
    end
    src = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R6: reset state, every input high
    check_pend("R6");
    apb_read('h100 + 4*5, rd);
    check(rd == 32'h0, "R6", "route word after reset", 128'(rd), 128'h0);

    // R1: control word count field
    apb_read('h00, rd);
    check(rd == 32'(NS << 2), "R1", "control word", 128'(rd), 128'(NS << 2));

    // R8: reads of command offsets return zero
    apb_read('h30, rd);
    check(rd == 32'h0, "R8", "read of set-enable offset", 128'(rd), 128'h0);
    apb_read('h34, rd);
    check(rd == 32'h0, "R8", "read of clear-enable offset", 128'(rd), 128'h0);

    // R5: private source pends without enable, clear has no effect
    route_write(3, 32'h0000_0002);
    check_pend("R5");
    check(irq_pend[1*NS+3] == 1'b1, "R5", "private src 3 core 1", 128'(irq_pend[1*NS+3]), 128'h1);
    en_write(0, 3);
    check_pend("R5");

    // R4 / R2: shared source 30 gated by its enable
    route_write(30, 32'h0000_0101);
    check(irq_pend[30] == 1'b0, "R4", "shared src 30 before enable", 128'(irq_pend[30]), 128'h0);
    en_write(1, 30);
    check_pend("R2");
    check(fiq_pend[30] == 1'b1, "R2", "shared src 30 fiq after set", 128'(fiq_pend[30]), 128'h1);
    en_write(0, 30);
    check_pend("R2");

    // R7: out-of-range and truncation-aliasing indices
    en_write(1, 94);
    check_pend("R7");
    en_write(1, NS);
    check_pend("R7");
    route_write(NS-1, 32'h0000_0303);
    en_write(1, NS-1);
    check_pend("R2");

    // R3: readback with unimplemented bits zero
    route_write(7, 32'hFFFF_FFFF);
    apb_read('h100 + 4*7, rd);
    check(rd == 32'h0000_0303, "R3", "route readback", 128'(rd), 128'h303);

    // R8: write past the last source does not alias
    route_write(NS, 32'h0000_0FFF);
    apb_read('h100, rd);
    check(rd == exp_word(0), "R8", "route word 0 after oob write", 128'(rd), 128'(exp_word(0)));
    apb_read('h100 + 4*NS, rd);
    check(rd == 32'h0, "R8", "read past last source", 128'(rd), 128'h0);
    check_pend("R8");

    // R9: write lands on the edge ending the access phase
    route_write(31, 32'h0000_0001);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = AW'('h30); pwdata = 31;
    @(negedge clk);
    penable = 1;
    check_pend("R9");
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    m_en[31] = 1;
    check_pend("R9");

    // Random traffic
    for (int it = 0; it < 500; it++) begin
      int op = $urandom % 4;
      int idx = $urandom % (NS + 6);
      case (op)
        0: begin en_write(1, 32'(idx)); check_pend("R2"); end
        1: begin en_write(0, 32'(idx)); check_pend("R4"); end
        2: begin route_write(idx, $urandom); check_pend("R3"); end
        default: begin
          @(negedge clk);
          src = NS'({$urandom, $urandom});
          check_pend("R9");
        end
      endcase
      if (it % 4 == 0) begin
        apb_read('h100 + 4*idx, rd);
        check(rd == exp_word(idx), "R3", "random route readback", 128'(rd), 128'(exp_word(idx)));
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule